// File: doc/BRIEF.md
# Rail Short-Circuit Fault Manager

This block watches a group of regulator rails: a set of switching-converter rails and a set of linear-regulator rails. For each rail it receives a requested enable and a raw short indication from the analog side. A short must be seen on an enabled rail for a fixed number of timebase ticks before it counts. A qualified short sets a sticky status bit for that rail, and that bit holds the rail's effective enable low until software clears it. The default window is 170 ticks of a 1 µs timebase derived from the system clock.

Each rail group has its own status word. Reading a status word returns its value and clears it. A level interrupt is high while any status bit is set, unless the interrupt mask bit is set. A startup timer blocks fault shutdown for a set time after reset. The timer restarts whenever any requested enable rises, so faults stay blocked while rails are still ramping up.

Top module: `rsf_fault_mgr`

## Requirements
- R1: A short is latched only after the raw indication stays high on an effectively enabled rail for FILT_US consecutive timebase ticks (one tick every TICK_DIV clocks). A shorter burst leaves the status bit clear.
- R2: A latched status bit forces that rail's effective enable output low and stays set until cleared by a read. Once the bit is cleared, a rail whose enable is still requested turns back on.
- R3: A read (rd_i high) at address 0 returns the switching-rail status word, and a read at address 1 returns the linear-rail status word. Bit i of the word is rail i. The data appears on rdata_o one cycle after the read, and the read clears that word.
- R4: If a short is latched in the same cycle as a clearing read of its word, the bit stays set. The read returns the value from before the read.
- R5: irq_o is high when any bit in either status word is set and the mask bit is 0. The mask bit is bit 0 at address 2, which can be written and read back.
- R6: After reset, no status bit is set until START_US ticks have passed.
- R7: A rising edge on any requested enable restarts the startup timer. While the timer runs, shutdown stays blocked.
- R8: The persistence count keeps running while shutdown is blocked. A short still present when blocking ends is latched right away.
- R9: A short on a rail whose enable is not requested is ignored.
- R10: After reset, both status words and the mask bit are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req_i | input | N_SW | Requested enables, switching rails |
| sw_short_i | input | N_SW | Raw short indications, switching rails |
| lin_req_i | input | N_LIN | Requested enables, linear rails |
| lin_short_i | input | N_LIN | Raw short indications, linear rails |
| sw_en_o | output | N_SW | Effective enables, switching rails |
| lin_en_o | output | N_LIN | Effective enables, linear rails |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is due on the clock edge after the read strobe, and the scoreboard monitor samples it 2 ns after that edge. A latched short reaches the rail enables and the interrupt between FILT_US×TICK_DIV and (FILT_US+1)×TICK_DIV+2 cycles after the short begins, because the tick phase is not fixed. For this reason the checks sample well before and well after that interval and never inside it. The startup-window checks use the same margins around START_US×TICK_DIV. The same-cycle case (R4) is covered by reading on every cycle while a short matures: across the whole run, exactly one read must return the bit.

// File: rtl/rsf_pkg.sv
`timescale 1ns/1ps
package rsf_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SW_STAT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIN_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK     = 2'd2;
endpackage

// File: rtl/rsf_tick.sv
`timescale 1ns/1ps
module rsf_tick #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(TICK_DIV - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/rsf_persist.sv
`timescale 1ns/1ps
module rsf_persist #(
  parameter int FILT_US = 170
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  output logic qual_o
);
  localparam int CW = $clog2(FILT_US + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full = (cnt_q == CW'(FILT_US));

  always_comb begin
    cnt_d = cnt_q;
    if (!arm_i)                cnt_d = '0;
    else if (tick_i && !full)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qual_o = full && arm_i;
endmodule

// File: rtl/rsf_startup.sv
`timescale 1ns/1ps
module rsf_startup #(
  parameter int START_US = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic masked_o
);
  localparam int CW = $clog2(START_US + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  assign done = (cnt_q == CW'(START_US));

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)            cnt_d = '0;
    else if (tick_i && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign masked_o = !done;
endmodule

// File: rtl/rsf_status.sv
`timescale 1ns/1ps
module rsf_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_i) stat_d = '0;
    stat_d = stat_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rsf_fault_mgr.sv
`timescale 1ns/1ps
module rsf_fault_mgr
  import rsf_pkg::*;
#(
  parameter int N_SW     = 6,
  parameter int N_LIN    = 8,
  parameter int DW       = 16,
  parameter int TICK_DIV = 200,
  parameter int FILT_US  = 170,
  parameter int START_US = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SW-1:0]   sw_req_i,
  input  logic [N_SW-1:0]   sw_short_i,
  input  logic [N_LIN-1:0]  lin_req_i,
  input  logic [N_LIN-1:0]  lin_short_i,
  output logic [N_SW-1:0]   sw_en_o,
  output logic [N_LIN-1:0]  lin_en_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  localparam int N_ALL = N_SW + N_LIN;

  logic              tick;
  logic              startup_masked;
  logic              any_rise;
  logic [N_ALL-1:0]  req_q;
  logic [N_SW-1:0]   sw_qual, sw_status;
  logic [N_LIN-1:0]  lin_qual, lin_status;
  logic              clr_sw, clr_lin;
  logic              mask_q, mask_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:1];

  rsf_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  // Rising edge of any requested enable restarts the startup window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= {lin_req_i, sw_req_i};
  end
  assign any_rise = |({lin_req_i, sw_req_i} & ~req_q);

  rsf_startup #(.START_US(START_US)) u_startup (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .restart_i(any_rise), .masked_o(startup_masked)
  );

  assign sw_en_o  = sw_req_i  & ~sw_status;
  assign lin_en_o = lin_req_i & ~lin_status;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw_filt
    rsf_persist #(.FILT_US(FILT_US)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .arm_i(sw_short_i[i] && sw_en_o[i]), .qual_o(sw_qual[i])
    );
  end

  for (genvar j = 0; j < N_LIN; j++) begin : g_lin_filt
    rsf_persist #(.FILT_US(FILT_US)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .arm_i(lin_short_i[j] && lin_en_o[j]), .qual_o(lin_qual[j])
    );
  end

  assign clr_sw  = rd_i && (addr_i == ADDR_SW_STAT);
  assign clr_lin = rd_i && (addr_i == ADDR_LIN_STAT);

  rsf_status #(.N(N_SW)) u_sw_stat (
    .clk(clk), .rst_n(rst_n),
    .set_i(sw_qual & {N_SW{!startup_masked}}),
    .clr_i(clr_sw), .stat_o(sw_status)
  );

  rsf_status #(.N(N_LIN)) u_lin_stat (
    .clk(clk), .rst_n(rst_n),
    .set_i(lin_qual & {N_LIN{!startup_masked}}),
    .clr_i(clr_lin), .stat_o(lin_status)
  );

  // Register port: next-state
  always_comb begin
    mask_d  = mask_q;
    rdata_d = rdata_q;
    if (wr_i && (addr_i == ADDR_MASK)) mask_d = wdata_i[0];
    if (rd_i) begin
      case (addr_i)
        ADDR_SW_STAT:  rdata_d = DW'(sw_status);
        ADDR_LIN_STAT: rdata_d = DW'(lin_status);
        ADDR_MASK:     rdata_d = DW'(mask_q);
        default:       rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = ((|sw_status) || (|lin_status)) && !mask_q;
endmodule

// File: rtl/rsf_fault_mgr_chk.sv
`timescale 1ns/1ps
module rsf_fault_mgr_chk
  import rsf_pkg::*;
#(
  parameter int N_SW  = 6,
  parameter int N_LIN = 8,
  parameter int DW    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic [DW-1:0]     rdata_o,
  input logic              irq_o,
  input logic              startup_masked,
  input logic [N_SW-1:0]   sw_qual,
  input logic [N_SW-1:0]   sw_status,
  input logic [N_LIN-1:0]  lin_qual,
  input logic [N_LIN-1:0]  lin_status
);
  AST_SET_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sw_status & ~$past(sw_status) & ~$past(sw_qual)) == '0) &&
              ((lin_status & ~$past(lin_status) & ~$past(lin_qual)) == '0)); // R1

  AST_STICKY_SW: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && addr_i == ADDR_SW_STAT) |=> ((sw_status & $past(sw_status)) == $past(sw_status))); // R2

  AST_RDATA_PREREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADDR_SW_STAT) |=> (rdata_o == DW'($past(sw_status)))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADDR_LIN_STAT && !startup_masked)
      |=> ((lin_status & $past(lin_qual)) == $past(lin_qual))); // R4

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|sw_status) || (|lin_status))); // R5

  AST_NO_SET_WHILE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    startup_masked |=> ((sw_status & ~$past(sw_status)) == '0) &&
                       ((lin_status & ~$past(lin_status)) == '0)); // R6
endmodule

bind rsf_fault_mgr rsf_fault_mgr_chk #(.N_SW(N_SW), .N_LIN(N_LIN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .startup_masked(startup_masked), .sw_qual(sw_qual),
  .sw_status(sw_status), .lin_qual(lin_qual), .lin_status(lin_status)
);

// File: tb/test_rsf_fault_mgr.sv
`timescale 1ns/1ps
module test_rsf_fault_mgr;
  localparam int N_SW = 3, N_LIN = 2, DW = 8;
  localparam int TICK_DIV = 2, FILT_US = 10, START_US = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SW-1:0]  sw_req = '0, sw_short = '0, sw_en;
  logic [N_LIN-1:0] lin_req = '0, lin_short = '0, lin_en;
  logic [1:0]       addr = '0;
  logic             rd = 1'b0, wr = 1'b0, chk_on = 1'b0;
  logic [DW-1:0]    wdata = '0, rdata;
  logic             irq;

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  rsf_fault_mgr #(.N_SW(N_SW), .N_LIN(N_LIN), .DW(DW), .TICK_DIV(TICK_DIV),
                  .FILT_US(FILT_US), .START_US(START_US)) i_rsf_fault_mgr (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .sw_short_i(sw_short),
    .lin_req_i(lin_req), .lin_short_i(lin_short), .sw_en_o(sw_en), .lin_en_o(lin_en),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: issue a read and push the expected data to the scoreboard
  task automatic sb_read(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1; chk_on = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0; chk_on = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // Monitor: compare read data 2 ns after the edge that captured it
  always @(posedge clk) begin
    if (rd && chk_on) begin
      #2;
      if (exp_q.size() == 0) check(rdata, '1, "scoreboard underflow");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hits;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    // R10 reset state
    check(DW'(irq), 0, "R10 irq after reset");
    check(DW'(sw_en), 0, "R10 sw_en after reset");
    sb_read(2'd2, 8'h00, "R10 mask after reset");
    sb_read(2'd0, 8'h00, "R10 sw status after reset");
    sb_read(2'd1, 8'h00, "R10 lin status after reset");

    // R6/R8: short during startup window is held off, then caught at window end
    sw_req = 3'b111; lin_req = 2'b11; sw_short[0] = 1'b1;
    wait_cyc(70);
    check(DW'(sw_en[0]), 1, "R6 rail stays on while masked");
    check(DW'(irq), 0, "R6 no irq while masked");
    wait_cyc(25);
    check(DW'(sw_en[0]), 0, "R8 caught at mask end, R2 rail off");
    check(DW'(irq), 1, "R5 irq on fault");
    sw_short[0] = 1'b0;
    wait_cyc(3);
    check(DW'(sw_en[0]), 0, "R2 rail stays off while bit set");
    sb_read(2'd0, 8'h01, "R3 sw status read");
    sb_read(2'd0, 8'h00, "R3 sw status cleared");
    check(DW'(sw_en[0]), 1, "R2 rail back on after clear");
    check(DW'(irq), 0, "R5 irq falls after clear");

    // R1: short burst below the window is ignored
    lin_short[1] = 1'b1; wait_cyc(14); lin_short[1] = 1'b0; wait_cyc(5);
    sb_read(2'd1, 8'h00, "R1 short burst ignored");
    lin_short[1] = 1'b1; wait_cyc(30);
    check(DW'(lin_en), 2'b01, "R1 lin rail1 off after full window");
    check(DW'(irq), 1, "R5 irq on lin fault");
    lin_short[1] = 1'b0;

    // R5: mask
    reg_write(2'd2, 8'h01);
    check(DW'(irq), 0, "R5 irq masked");
    sb_read(2'd2, 8'h01, "R5 mask readback");
    reg_write(2'd2, 8'h00);
    check(DW'(irq), 1, "R5 irq unmasked");
    sb_read(2'd1, 8'h02, "R3 lin status read");
    check(DW'(irq), 0, "R5 irq low after lin clear");

    // R9: short on a rail not requested
    sw_req[2] = 1'b0; sw_short[2] = 1'b1; wait_cyc(40);
    check(DW'(irq), 0, "R9 no irq for disabled rail");
    sb_read(2'd0, 8'h00, "R9 disabled rail status clear");
    sw_short[2] = 1'b0;

    // R4: back-to-back reads while a short matures; bit must be seen exactly once
    hits = 0;
    @(negedge clk);
    sw_short[1] = 1'b1; addr = 2'd0; rd = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2;
      if (rdata[1]) hits++;
      if (k == 29) sw_short[1] = 1'b0;
    end
    @(negedge clk); rd = 1'b0;
    check(DW'(hits), 1, "R4 set wins over same-cycle clear");
    check(DW'(sw_en[1]), 1, "R2 rail1 back on");

    // R7: new rail enable restarts the startup window
    sw_req[2] = 1'b1; lin_short[0] = 1'b1;
    wait_cyc(60);
    check(DW'(lin_en[0]), 1, "R7 masked again after enable rise");
    wait_cyc(40);
    check(DW'(lin_en[0]), 0, "R7 fault after restarted window");
    lin_short[0] = 1'b0;
    sb_read(2'd1, 8'h01, "R7 lin status after window");

    wait_cyc(3);
    check(DW'(exp_q.size()), 0, "scoreboard drained");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule